// File: doc/BRIEF.md
# Interrupt Trigger-Mode Conditioner

This block sits between sixteen raw interrupt request wires and a downstream interrupt controller. For each line it produces a clean, active-high request. A 16-bit trigger-mode register decides how each wire is read. With a mode bit of 0 the line is edge-sensitive: the block watches the synchronized input for a rising edge and holds a sticky pending request until the controller acknowledges it. With a mode bit of 1 the line is level-sensitive and active-low: the request follows the inverted synchronized input and holds no state.

Host software reaches the mode register through a byte-wide I/O port interface. The register is split across two adjacent byte addresses. Five lines are permanently edge-sensitive: their mode bits read as zero and writes to them are dropped. Every raw input first passes through a two-flop synchronizer. The I/O interface has no back-pressure. The block accepts a read or write strobe on every cycle, and each mapped read answers exactly one cycle later with a one-cycle valid strobe. The acknowledge inputs are plain per-line pulses.

Top module: `irq_trig_cond`

## Requirements
- R1: After reset every mode bit is 0 (all lines edge-sensitive), no pending request exists, `irq_req` is all zeros and `io_rvalid` is low.
- R2: Mode bit n controls line n only. Value 0 selects edge sensing and value 1 selects level sensing.
- R3: On an edge-sensitive line, a 0-to-1 change of the raw input raises `irq_req[n]` on the third rising clock edge after the change (two synchronizer stages plus the pending flop). The request then stays high after the input falls, until it is acknowledged.
- R4: A one-cycle `irq_ack[n]` clears the pending request on the next edge. If a newly synchronized rising edge arrives in the same cycle as the acknowledge, the request stays set.
- R5: On a level-sensitive line, `irq_req[n]` equals the inverted raw input delayed by two clock edges, and it does not latch.
- R6: Byte address 0x4D0 maps mode bits 7..0 (lines 0-7) onto data bits 7..0. Byte address 0x4D1 maps mode bits 15..8 (lines 8-15) onto data bits 7..0.
- R7: A write to one byte address changes only that byte's eight mode bits.
- R8: Mode bits 0, 1, 2, 8 and 13 always read 0 and ignore writes, so those lines stay edge-sensitive.
- R9: A read of a mapped address gives `io_rvalid`=1 and the byte on `io_rdata` in the next cycle. A read or write at any other address produces no `io_rvalid` and changes no mode bit.
- R10: Setting a line to level mode clears any pending edge request on that line, so returning the line to edge mode shows no stale request.
- R11: On an edge-sensitive line, a 1-to-0 change of the input raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_irq | input | 16 | Asynchronous raw interrupt wires |
| irq_ack | input | 16 | Per-line acknowledge pulses from the controller |
| irq_req | output | 16 | Conditioned active-high requests |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | High for one cycle after a mapped read |

## Verification
The assertions check the following on every cycle: the permanently-edge bits stay zero, a write leaves the other byte unchanged, the read-valid strobe follows decoded reads, the pending flag stays set until acknowledged, the set wins when it meets an acknowledge, and no pending state exists in level mode. Only the bench scenarios can show the rest: the exact synchronizer latency seen at the pins, the readback byte values and their bit positions, level-mode following without latching, and the absence of a stale request after a round trip from edge mode to level mode and back.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IO_AW = 16;
  localparam logic [IO_AW-1:0] DEF_BASE_ADDR = 16'h04D0;

  // Select the byte lane b of a mode word.
  function automatic logic [BYTE_W-1:0] lane_of(input logic [63:0] word, input int unsigned b);
    return word[b*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_in;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/trig_mode_regs.sv
module trig_mode_regs
  import irq_trig_pkg::*;
#(
  parameter int unsigned      N_LINES   = 16,
  parameter logic [IO_AW-1:0] BASE_ADDR = DEF_BASE_ADDR,
  parameter logic [N_LINES-1:0] FORCE_EDGE = 16'h2107
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IO_AW-1:0]   io_addr,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [BYTE_W-1:0]  io_wdata,
  output logic [BYTE_W-1:0]  io_rdata,
  output logic               io_rvalid,
  output logic [N_LINES-1:0] mode
);
  localparam int unsigned N_BYTES = N_LINES / BYTE_W;

  logic [N_LINES-1:0] mode_q;
  logic [N_BYTES-1:0] wr_hit, rd_hit;
  logic [BYTE_W-1:0]  rd_mux;
  logic [BYTE_W-1:0]  rdata_q;
  logic               rvalid_q;

  for (genvar b = 0; b < int'(N_BYTES); b++) begin : g_byte
    localparam logic [IO_AW-1:0] ADDR_B = BASE_ADDR + IO_AW'(b);
    localparam logic [BYTE_W-1:0] KEEP0 = ~FORCE_EDGE[b*BYTE_W +: BYTE_W];
    assign wr_hit[b] = io_wr && (io_addr == ADDR_B);
    assign rd_hit[b] = io_rd && (io_addr == ADDR_B);

    always_ff @(posedge clk) begin
      if (!rst_n) mode_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (wr_hit[b]) mode_q[b*BYTE_W +: BYTE_W] <= io_wdata & KEEP0;
    end

    // R7: a write elsewhere leaves this byte alone
    assert_other_byte_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit[b]) |=> $stable(mode_q[b*BYTE_W +: BYTE_W]));
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < int'(N_BYTES); b++)
      if (rd_hit[b]) rd_mux = mode_q[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rd_mux;
      rvalid_q <= |rd_hit;
    end
  end

  assign mode      = mode_q;
  assign io_rdata  = rdata_q;
  assign io_rvalid = rvalid_q;

  assert_force_edge_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & FORCE_EDGE) == '0);
  assert_rvalid_follows_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_hit) |=> io_rvalid);
  assert_no_rvalid_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|rd_hit)) |=> !io_rvalid);
endmodule

// File: rtl/irq_line_cond.sv
module irq_line_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic level_mode,
  input  logic sync_in,
  input  logic ack,
  output logic req
);
  logic prev_q, pend_q, rise;

  assign rise = sync_in & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_in;
      if (level_mode)  pend_q <= 1'b0;
      else if (rise)   pend_q <= 1'b1;
      else if (ack)    pend_q <= 1'b0;
    end
  end

  assign req = level_mode ? ~sync_in : pend_q;

  assert_set_beats_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && rise && ack) |=> pend_q);
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !rise && ack) |=> !pend_q);
  assert_sticky_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && pend_q && !ack) |=> pend_q);
  assert_level_drops_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode |=> !pend_q);
endmodule

// File: rtl/irq_trig_cond.sv
module irq_trig_cond
  import irq_trig_pkg::*;
#(
  parameter int unsigned        N_LINES    = 16,
  parameter int unsigned        SYNC_DEPTH = 2,
  parameter logic [IO_AW-1:0]   BASE_ADDR  = DEF_BASE_ADDR,
  parameter logic [N_LINES-1:0] FORCE_EDGE = 16'h2107
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] raw_irq,
  input  logic [N_LINES-1:0] irq_ack,
  output logic [N_LINES-1:0] irq_req,
  input  logic [IO_AW-1:0]   io_addr,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [BYTE_W-1:0]  io_wdata,
  output logic [BYTE_W-1:0]  io_rdata,
  output logic               io_rvalid
);
  logic [N_LINES-1:0] mode;
  logic [N_LINES-1:0] synced;

  trig_mode_regs #(
    .N_LINES(N_LINES), .BASE_ADDR(BASE_ADDR), .FORCE_EDGE(FORCE_EDGE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid), .mode(mode)
  );

  irq_sync #(.WIDTH(N_LINES), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(raw_irq), .q_out(synced)
  );

  for (genvar n = 0; n < int'(N_LINES); n++) begin : g_line
    irq_line_cond u_line (
      .clk(clk), .rst_n(rst_n), .level_mode(mode[n]), .sync_in(synced[n]),
      .ack(irq_ack[n]), .req(irq_req[n])
    );
  end
endmodule

// File: tb/irq_trig_cond_bench.sv
module irq_trig_cond_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] A_LO = 16'h04D0;
  localparam logic [15:0] A_HI = 16'h04D1;
  localparam logic [15:0] FIXED = 16'h2107;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] raw_irq = '0, irq_ack = '0, irq_req, io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0, io_rvalid;
  logic [7:0] io_wdata = '0, io_rdata;

  int n_tests = 0, n_fail = 0;
  logic [15:0] mdl = '0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_trig_cond u_irq_trig_cond (
    .clk(clk), .rst_n(rst_n), .raw_irq(raw_irq), .irq_ack(irq_ack), .irq_req(irq_req),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid)
  );

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    if (a == A_LO) mdl[7:0]  = d & ~FIXED[7:0];
    if (a == A_HI) mdl[15:8] = d & ~FIXED[15:8];
    tick();
    io_wr = 1'b0;
  endtask

  task automatic io_read(logic [15:0] a, string tag);
    io_addr = a; io_rd = 1'b1;
    if (a == A_LO) begin exp_q.push_back(mdl[7:0]);  tag_q.push_back(tag); end
    if (a == A_HI) begin exp_q.push_back(mdl[15:8]); tag_q.push_back(tag); end
    tick();
    io_rd = 1'b0;
    tick();
  endtask

  // Monitor: pops the scoreboard whenever a read result appears.
  always @(negedge clk) begin
    if (rst_n && io_rvalid) begin
      if (exp_q.size() == 0) chk("R9 unexpected rvalid", 1, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, io_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(3);
    rst_n = 1'b1;
    tick();
    chk("R1 req after reset", irq_req, 16'h0);
    chk("R1 rvalid after reset", io_rvalid, 0);
    io_read(A_LO, "R1 low byte reset");
    io_read(A_HI, "R1 high byte reset");

    // R8/R6: forced-edge bits read zero
    io_write(A_LO, 8'hFF);
    io_write(A_HI, 8'hFF);
    io_read(A_LO, "R8 low byte 0xF8");
    io_read(A_HI, "R8 high byte 0xDE");
    // R7: low write leaves high byte
    io_write(A_LO, 8'h00);
    io_read(A_HI, "R7 high byte kept");
    io_read(A_LO, "R6 low byte cleared");
    // R9: unmapped address
    io_write(16'h04D2, 8'hFF);
    io_read(16'h04D2, "R9 unmapped read");
    io_read(A_LO, "R9 unmapped write ignored");
    io_read(A_HI, "R9 high after unmapped");

    // R5/R2: level lines with input low are requesting, edge lines idle
    chk("R5 level lines asserted", irq_req & 16'hDE00, 16'hDE00);
    chk("R2 edge lines idle", irq_req & ~16'hDE00, 16'h0);
    raw_irq[9] = 1'b1;
    tick();
    chk("R5 level latency one edge", irq_req[9], 1);
    tick();
    chk("R5 level released", irq_req[9], 0);
    raw_irq[9] = 1'b0;
    tick(2);
    chk("R5 level no latch", irq_req[9], 1);

    // R8/R3: line 8 is edge despite 0xFF write
    raw_irq[8] = 1'b1;
    tick(2);
    chk("R3 edge latency not yet", irq_req[8], 0);
    tick();
    chk("R3 edge request raised", irq_req[8], 1);
    chk("R8 line 8 stays edge", irq_req[8], 1);
    raw_irq[8] = 1'b0;
    tick(3);
    chk("R3 sticky after input falls", irq_req[8], 1);
    irq_ack[8] = 1'b1;
    tick();
    irq_ack[8] = 1'b0;
    chk("R4 ack clears", irq_req[8], 0);

    // R11: falling edge gives nothing
    raw_irq[3] = 1'b1;
    tick(3);
    irq_ack[3] = 1'b1;
    tick();
    irq_ack[3] = 1'b0;
    raw_irq[3] = 1'b0;
    tick(4);
    chk("R11 falling edge ignored", irq_req[3], 0);

    // R4: new edge and ack in the same cycle
    raw_irq[5] = 1'b1;
    tick(2);
    irq_ack[5] = 1'b1;
    tick();
    irq_ack[5] = 1'b0;
    chk("R4 set wins over ack", irq_req[5], 1);

    // R10: stale pending dropped on level switch
    raw_irq[6] = 1'b1;
    tick(3);
    chk("R10 line 6 pending", irq_req[6], 1);
    io_write(A_LO, 8'h40);
    tick();
    chk("R2 line 6 level, input high", irq_req[6], 0);
    io_write(A_LO, 8'h00);
    tick(2);
    chk("R10 no stale request", irq_req[6], 0);

    tick(3);
    chk("R9 all reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule